// File: doc/BRIEF.md
# Immediate-Count Shift Execute Unit

This block is the execute stage for the shift-by-immediate instruction group of a 32-bit core. Each cycle in which the valid strobe is high, it takes a decoded ModR/M byte, a source operand and an 8-bit immediate count. The three middle bits of the ModR/M byte select the kind of shift: left, logical right, or arithmetic right. One clock later it presents the shifted value with a write-enable, or it raises an error pulse when the selector is not one of the three supported codes.

The sign, zero and overflow flags are architectural state held inside the unit. Sign and zero follow every accepted shift. Overflow changes only when the effective count is exactly one, so it can carry over from earlier instructions. The caller resolves operand addressing before the unit sees the operand. The mode and register fields of the ModR/M byte therefore have no effect here.

Top module: `imm_shift_unit`

## Requirements
- R1: Only bits 4:0 of `shamt_imm` form the effective count (0 to 31); bits 7:5 have no effect on result or flags.
- R2: With `modrm[5:3]` = 3'b100 the result is the operand shifted left, zero filled. `modrm[7:6]` and `modrm[2:0]` have no effect. Example: 13 shifted by 1 gives 0x1A.
- R3: With `modrm[5:3]` = 3'b101 the result is a logical right shift with zero fill. After such a shift `flag_sign` is 0. Example: 0xFFFFFFFD by 1 gives 0x7FFFFFFE.
- R4: With `modrm[5:3]` = 3'b111 the result is an arithmetic right shift that copies bit 31 into the vacated bits. Examples for a count of 1: 26 gives 13, 27 gives 13, and 0xFFFFFFFD gives 0xFFFFFFFE.
- R5: After any accepted shift, `flag_zero` is 1 exactly when the result is zero. After a left or arithmetic-right shift, `flag_sign` equals result bit 31.
- R6: When the effective count is 1, `flag_ovf` is updated as follows. For a left shift it becomes operand bit 31 XOR operand bit 30. For an arithmetic right shift it becomes 0. For a logical right shift it becomes operand bit 31.
- R7: For any effective count other than 1, `flag_ovf` keeps its previous value. An effective count of 0 returns the operand unchanged.
- R8: A selector other than 4, 5 or 7 gives a one-cycle `bad_subop` pulse with `dst_we` low. `dst_val` then shows the unmodified operand, and all three flags keep their values.
- R9: Outputs appear on the clock edge after the strobe. With no strobe, `dst_we` and `bad_subop` stay 0, and `dst_val` and the flags hold.
- R10: During and after reset, `dst_val`, `dst_we`, all three flags and `bad_subop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Strobe: the inputs carry one instruction this cycle |
| modrm | input | 8 | ModR/M byte; bits 5:3 choose the shift kind |
| src_val | input | 32 | Operand to be shifted |
| shamt_imm | input | 8 | Immediate shift count |
| dst_val | output | 32 | Shifted value, or the untouched operand on an error |
| dst_we | output | 1 | One-cycle write-enable for `dst_val` |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_ovf | output | 1 | Overflow flag |
| bad_subop | output | 1 | One-cycle pulse for an unsupported selector |

## Verification
The overflow flag is the only state that crosses instruction boundaries. If it is corrupted, the error stays invisible until an instruction with a count other than one reads the held value back. The vector sequence is therefore ordered so that overflow is set to 1 by one shift and then observed through several later shifts with counts 0, 4 and 31. It is also observed through an illegal selector. A bad stage in the shifter or a wrong fill bit shows at `dst_val` on the first edge after the strobe. The vectors place single set bits at both ends of the word to expose such faults.

// File: rtl/imm_shift_pkg.sv
package imm_shift_pkg;

    typedef enum logic [1:0] {
        SK_LEFT   = 2'd0,
        SK_RLOG   = 2'd1,
        SK_RARITH = 2'd2,
        SK_NONE   = 2'd3
    } shift_kind_e;

    localparam logic [2:0] SEL_LEFT   = 3'd4;
    localparam logic [2:0] SEL_RLOG   = 3'd5;
    localparam logic [2:0] SEL_RARITH = 3'd7;

endpackage

// File: rtl/imm_shift_decode.sv
module imm_shift_decode
    import imm_shift_pkg::*;
#(
    parameter int IMM_W = 8,
    parameter int CNT_W = 5
) (
    input  logic [7:0]       modrm,
    input  logic [IMM_W-1:0] shamt_imm,
    output shift_kind_e      kind,
    output logic             legal,
    output logic [CNT_W-1:0] amt
);
    logic [2:0] sel;

    always_comb begin
        sel = modrm[5:3];
        unique case (sel)
            SEL_LEFT:   kind = SK_LEFT;
            SEL_RLOG:   kind = SK_RLOG;
            SEL_RARITH: kind = SK_RARITH;
            default:    kind = SK_NONE;
        endcase
        legal = (kind != SK_NONE);
        amt   = shamt_imm[CNT_W-1:0];
    end
endmodule

// File: rtl/imm_shift_barrel.sv
module imm_shift_barrel #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic [DATA_W-1:0] din,
    input  logic [CNT_W-1:0]  amt,
    input  logic              go_left,
    input  logic              fill_bit,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] din_rev;
    logic [DATA_W-1:0] mid_rev;
    logic [DATA_W-1:0] stage [0:CNT_W];

    // Left shifts reuse the right-shift network on a bit-reversed word.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rev
        assign din_rev[b] = din[DATA_W-1-b];
        assign mid_rev[b] = stage[CNT_W][DATA_W-1-b];
    end

    assign stage[0] = go_left ? din_rev : din;

    for (genvar s = 0; s < CNT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s]
            ? {{STEP{fill_bit}}, stage[s][DATA_W-1:STEP]}
            : stage[s];
    end

    assign dout = go_left ? mid_rev : stage[CNT_W];
endmodule

// File: rtl/imm_shift_flags.sv
module imm_shift_flags
    import imm_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input  shift_kind_e       kind,
    input  logic [CNT_W-1:0]  amt,
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] shifted,
    input  logic              ovf_prev,
    output logic              sign_nx,
    output logic              zero_nx,
    output logic              ovf_nx
);
    logic single;

    always_comb begin
        single  = (amt == CNT_W'(1));
        zero_nx = (shifted == '0);
        sign_nx = (kind == SK_RLOG) ? 1'b0 : shifted[DATA_W-1];
        ovf_nx  = ovf_prev;
        if (single) begin
            unique case (kind)
                SK_LEFT:   ovf_nx = opnd[DATA_W-1] ^ opnd[DATA_W-2];
                SK_RLOG:   ovf_nx = opnd[DATA_W-1];
                SK_RARITH: ovf_nx = 1'b0;
                default:   ovf_nx = ovf_prev;
            endcase
        end
    end
endmodule

// File: rtl/imm_shift_unit.sv
module imm_shift_unit
    import imm_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        modrm,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  shamt_imm,
    output logic [DATA_W-1:0] dst_val,
    output logic              dst_we,
    output logic              flag_sign,
    output logic              flag_zero,
    output logic              flag_ovf,
    output logic              bad_subop
);
    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        logic              sf;
        logic              zf;
        logic              of;
        logic              err;
    } unit_state_t;

    unit_state_t st_d, st_q;

    shift_kind_e       kind;
    logic              legal;
    logic [CNT_W-1:0]  amt;
    logic [DATA_W-1:0] shifted;
    logic              sign_nx, zero_nx, ovf_nx;

    imm_shift_decode #(.IMM_W(IMM_W), .CNT_W(CNT_W)) u_decode (
        .modrm     (modrm),
        .shamt_imm (shamt_imm),
        .kind      (kind),
        .legal     (legal),
        .amt       (amt)
    );

    imm_shift_barrel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_barrel (
        .din      (src_val),
        .amt      (amt),
        .go_left  (kind == SK_LEFT),
        .fill_bit ((kind == SK_RARITH) & src_val[DATA_W-1]),
        .dout     (shifted)
    );

    imm_shift_flags #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_flags (
        .kind     (kind),
        .amt      (amt),
        .opnd     (src_val),
        .shifted  (shifted),
        .ovf_prev (st_q.of),
        .sign_nx  (sign_nx),
        .zero_nx  (zero_nx),
        .ovf_nx   (ovf_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;
        st_d.err = 1'b0;
        if (op_valid) begin
            if (legal) begin
                st_d.res = shifted;
                st_d.we  = 1'b1;
                st_d.sf  = sign_nx;
                st_d.zf  = zero_nx;
                st_d.of  = ovf_nx;
            end else begin
                st_d.res = src_val;
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dst_val   = st_q.res;
    assign dst_we    = st_q.we;
    assign flag_sign = st_q.sf;
    assign flag_zero = st_q.zf;
    assign flag_ovf  = st_q.of;
    assign bad_subop = st_q.err;
endmodule

// File: rtl/imm_shift_unit_chk.sv
module imm_shift_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [7:0]        modrm,
    input logic [IMM_W-1:0]  shamt_imm,
    input logic [DATA_W-1:0] dst_val,
    input logic              dst_we,
    input logic              flag_sign,
    input logic              flag_zero,
    input logic              flag_ovf,
    input logic              bad_subop
);
    AST_WE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we || bad_subop) |-> $past(op_valid)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(op_valid) |-> ($stable(dst_val) && $stable(flag_ovf))); // R9

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dst_we, bad_subop})); // R8

    AST_ERR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        bad_subop |-> ($stable(flag_sign) && $stable(flag_zero) && $stable(flag_ovf))); // R8

    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> (flag_zero == (dst_val == '0))); // R5

    AST_RLOG_SIGN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && $past(modrm[5:3] == 3'd5)) |-> !flag_sign); // R3

    AST_OVF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && $past(shamt_imm[4:0] != 5'd1)) |-> $stable(flag_ovf)); // R7
endmodule

bind imm_shift_unit imm_shift_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .modrm     (modrm),
    .shamt_imm (shamt_imm),
    .dst_val   (dst_val),
    .dst_we    (dst_we),
    .flag_sign (flag_sign),
    .flag_zero (flag_zero),
    .flag_ovf  (flag_ovf),
    .bad_subop (bad_subop)
);

// File: tb/imm_shift_unit_bench.sv
module imm_shift_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  modrm = '0;
    logic [31:0] src_val = '0;
    logic [7:0]  shamt_imm = '0;
    logic [31:0] dst_val;
    logic        dst_we, flag_sign, flag_zero, flag_ovf, bad_subop;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    imm_shift_unit u_imm_shift_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .modrm(modrm),
        .src_val(src_val), .shamt_imm(shamt_imm), .dst_val(dst_val),
        .dst_we(dst_we), .flag_sign(flag_sign), .flag_zero(flag_zero),
        .flag_ovf(flag_ovf), .bad_subop(bad_subop)
    );

    // {modrm, operand, count, expected result, sign, zero, ovf}
    localparam int NV = 15;
    localparam logic [82:0] VEC [NV] = '{
        {8'hE3, 32'h0000000D, 8'h01, 32'h0000001A, 3'b000}, // R2
        {8'hFB, 32'h0000001A, 8'h01, 32'h0000000D, 3'b000}, // R4
        {8'hFB, 32'h0000001B, 8'h01, 32'h0000000D, 3'b000}, // R4
        {8'hFB, 32'hFFFFFFFD, 8'h01, 32'hFFFFFFFE, 3'b100}, // R4 R5
        {8'hEB, 32'hFFFFFFFD, 8'h01, 32'h7FFFFFFE, 3'b001}, // R3 R6
        {8'hE3, 32'h40000000, 8'h01, 32'h80000000, 3'b101}, // R6
        {8'hE3, 32'h80000000, 8'h01, 32'h00000000, 3'b011}, // R5 R6
        {8'hE3, 32'h12345678, 8'h24, 32'h23456780, 3'b001}, // R1 R7
        {8'hFB, 32'h80000000, 8'h1F, 32'hFFFFFFFF, 3'b101}, // R4 R7
        {8'hEB, 32'h80000000, 8'h1F, 32'h00000001, 3'b001}, // R3
        {8'hFB, 32'hC0000000, 8'h01, 32'hE0000000, 3'b100}, // R6
        {8'h23, 32'h00000001, 8'h1F, 32'h80000000, 3'b100}, // R2
        {8'hE3, 32'h40000001, 8'h01, 32'h80000002, 3'b101}, // R6
        {8'hEB, 32'h0000FFFF, 8'h20, 32'h0000FFFF, 3'b001}, // R1 R7
        {8'hFB, 32'h00000000, 8'h05, 32'h00000000, 3'b011}  // R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] m, input logic [31:0] v, input logic [7:0] c);
        @(negedge clk);
        modrm = m; src_val = v; shamt_imm = c; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset outputs", {dst_val[31:0]}, 32'h0);
        chk("R10 reset flags", {27'b0, dst_we, flag_sign, flag_zero, flag_ovf, bad_subop}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][82:75], VEC[i][74:43], VEC[i][42:35]);
            chk($sformatf("R2/R3/R4 result vec%0d", i), dst_val, VEC[i][34:3]);
            chk($sformatf("R5/R6/R7 flags vec%0d", i),
                {29'b0, flag_sign, flag_zero, flag_ovf}, {29'b0, VEC[i][2:0]});
            chk($sformatf("R9 we vec%0d", i), {31'b0, dst_we}, 32'h1);
        end

        // R8: every unsupported selector, flags held at sign0 zero1 ovf1
        for (int s = 0; s < 8; s++) begin
            if (s == 4 || s == 5 || s == 7) continue;
            issue({2'b11, 3'(s), 3'b011}, 32'hABCD0000 + s, 8'h01);
            chk($sformatf("R8 err sel%0d", s), {30'b0, bad_subop, dst_we}, 32'h2);
            chk($sformatf("R8 operand sel%0d", s), dst_val, 32'hABCD0000 + s);
            chk($sformatf("R8 flags sel%0d", s),
                {29'b0, flag_sign, flag_zero, flag_ovf}, 32'h3);
        end

        // R9: idle cycles hold state and keep pulses low
        @(negedge clk);
        modrm = 8'hE3; src_val = 32'h5; shamt_imm = 8'h1;
        @(negedge clk);
        chk("R9 idle pulses", {30'b0, dst_we, bad_subop}, 32'h0);
        chk("R9 idle result hold", dst_val, 32'hABCD0006);
        chk("R9 idle flags hold", {29'b0, flag_sign, flag_zero, flag_ovf}, 32'h3);

        // R7: count 0 returns operand on a left shift, ovf kept
        issue(8'hE3, 32'h87654321, 8'hE0);
        chk("R7 count zero result", dst_val, 32'h87654321);
        chk("R7 count zero flags", {29'b0, flag_sign, flag_zero, flag_ovf}, 32'h5);

        // R10: reset mid-run clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 reset clears", {dst_val[31:1], flag_ovf}, 32'h0);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule